// File: doc/BRIEF.md
# Masked Vector Subtract Unit

This unit runs predicated element-wise vector work on a small on-block vector register file. A compare instruction sets a per-element predicate. Each element of a chosen vector register is tested against a scalar, and its predicate bit is set to 1 when the two values differ. A masked subtract then changes only the elements whose predicate bit is 1. The other elements of the destination register are not written. A clear instruction sets every predicate bit back to 1, so later subtracts act on every element. With this pair of instructions, a loop body guarded by an "if element is non-zero" test can run as two vector instructions.

Instructions arrive on a two-bit opcode input that is sampled every clock. Compare and subtract take one element per clock in ascending index order. While they run, `busy` is high. `done` pulses for one cycle after the last element. A clear finishes in one cycle. A host port loads and reads the register file. It writes one element per clock while the unit is idle and reads one element combinationally. The whole predicate register is visible on `mask_o`. The reset input is asserted asynchronously and released through a two-stage synchroniser.

Top module: `vmx_unit`

## Requirements
- R1: After reset, `busy` and `done` are low and every bit of `mask_o` is 1.
- R2: Opcode 2'b01 (compare) goes through elements 0 to VLEN-1 of register `op_va`, one per clock in index order. It sets `mask_o[i]` to 1 when element i differs from `scalar_in`, and to 0 when they are equal.
- R3: Opcode 2'b11 (clear) sets every bit of `mask_o` to 1 at the accepting edge. `done` is high for the following cycle, and `busy` stays low.
- R4: Opcode 2'b10 (subtract) sets element i of register `op_va` to its value minus element i of register `op_vb`, modulo 2^W, for every i whose mask bit is 1.
- R5: During a subtract, an element whose mask bit is 0 is not written and keeps its earlier value.
- R6: An accepted compare or subtract raises `busy` at the next edge, and `busy` stays high for exactly VLEN cycles.
- R7: `done` is high for the one cycle that follows the processing of element VLEN-1. `busy` falls in that same cycle.
- R8: A non-zero opcode presented while `busy` is high is ignored. It does not change the running operation, the mask or the register file.
- R9: A host write (`host_we`) while idle updates the addressed element at the next edge. A host write while `busy` is high is dropped. `host_rdata` always shows the element at `host_rreg`/`host_ridx`.
- R10: An instruction can be issued in the cycle where `done` is high. A subtract issued right after a compare uses the complete mask that the compare produced.
- R11: Opcode 2'b00 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 2 | 00 none, 01 compare-not-equal, 10 masked subtract, 11 clear mask |
| op_va | input | $clog2(NREGS) | Compare source / subtract destination and minuend register |
| op_vb | input | $clog2(NREGS) | Subtract subtrahend register |
| scalar_in | input | W | Scalar for the compare |
| busy | output | 1 | Vector operation in progress |
| done | output | 1 | One-cycle completion pulse |
| host_we | input | 1 | Host element write enable |
| host_wreg | input | $clog2(NREGS) | Host write register |
| host_widx | input | $clog2(VLEN) | Host write element index |
| host_wdata | input | W | Host write data |
| host_rreg | input | $clog2(NREGS) | Host read register |
| host_ridx | input | $clog2(VLEN) | Host read element index |
| host_rdata | output | W | Host read data |
| mask_o | output | VLEN | Predicate register |

## Verification
Two collisions can occur in one cycle. An element write-back by the engine can meet a host write, and a new opcode can meet a running operation. The bench provokes both by driving a host write and a clear and compare opcode in the middle of a subtract. It judges them by reading the targeted elements back afterwards and by comparing the mask every clock. The bench also issues a subtract in the exact cycle that `done` of a compare is high. Its reference model then requires every zero-valued element to come through the subtract unchanged.

// File: rtl/vmx_pkg.sv
`timescale 1ns/1ps
package vmx_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_SNE  = 2'b01,
    OP_SUBM = 2'b10,
    OP_CLRM = 2'b11
  } vmx_op_e;
endpackage

// File: rtl/vmx_regfile.sv
`timescale 1ns/1ps
module vmx_regfile #(
  parameter int W     = 16,
  parameter int VLEN  = 64,
  parameter int NREGS = 4,
  localparam int IW   = $clog2(VLEN),
  localparam int RW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eng_we_i,
  input  logic [RW-1:0] eng_wreg_i,
  input  logic [IW-1:0] eng_widx_i,
  input  logic [W-1:0]  eng_wdata_i,
  input  logic          host_we_i,
  input  logic [RW-1:0] host_wreg_i,
  input  logic [IW-1:0] host_widx_i,
  input  logic [W-1:0]  host_wdata_i,
  input  logic [RW-1:0] pa_reg_i,
  input  logic [IW-1:0] pa_idx_i,
  output logic [W-1:0]  pa_data_o,
  input  logic [RW-1:0] pb_reg_i,
  input  logic [IW-1:0] pb_idx_i,
  output logic [W-1:0]  pb_data_o,
  input  logic [RW-1:0] pc_reg_i,
  input  logic [IW-1:0] pc_idx_i,
  output logic [W-1:0]  pc_data_o
);
  localparam int DEPTH = NREGS * VLEN;
  localparam int AW    = RW + IW;

  logic [W-1:0]  store_q [DEPTH];
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [W-1:0]  wr_data;

  always_comb begin
    wr_en   = eng_we_i | host_we_i;
    wr_addr = eng_we_i ? {eng_wreg_i, eng_widx_i} : {host_wreg_i, host_widx_i};
    wr_data = eng_we_i ? eng_wdata_i : host_wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) store_q[wr_addr] <= wr_data;
  end

  assign pa_data_o = store_q[{pa_reg_i, pa_idx_i}];
  assign pb_data_o = store_q[{pb_reg_i, pb_idx_i}];
  assign pc_data_o = store_q[{pc_reg_i, pc_idx_i}];

  // R9
  wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eng_we_i && host_we_i));
endmodule

// File: rtl/vmx_mask.sv
`timescale 1ns/1ps
module vmx_mask #(
  parameter int VLEN = 64,
  localparam int IW  = $clog2(VLEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            set_en_i,
  input  logic [IW-1:0]   set_idx_i,
  input  logic            set_val_i,
  output logic [VLEN-1:0] mask_o
);
  logic [VLEN-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (clr_i)         mask_d = '1;
    else if (set_en_i) mask_d[set_idx_i] = set_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '1;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // R3
  clr_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (&mask_q));
  // R2
  mask_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_en_i) |=> $stable(mask_q));
endmodule

// File: rtl/vmx_seq.sv
`timescale 1ns/1ps
module vmx_seq
  import vmx_pkg::*;
#(
  parameter int W     = 16,
  parameter int VLEN  = 64,
  parameter int NREGS = 4,
  localparam int IW   = $clog2(VLEN),
  localparam int RW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    op_code_i,
  input  logic [RW-1:0] op_va_i,
  input  logic [RW-1:0] op_vb_i,
  input  logic [W-1:0]  scalar_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          clr_o,
  output logic [IW-1:0] idx_o,
  output vmx_op_e       op_o,
  output logic [RW-1:0] va_o,
  output logic [RW-1:0] vb_o,
  output logic [W-1:0]  scalar_o
);
  localparam logic [IW-1:0] LAST_IDX = IW'(VLEN - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [IW-1:0] idx_q, idx_d;
  vmx_op_e       op_q;
  logic [RW-1:0] va_q, vb_q;
  logic [W-1:0]  sc_q;
  logic          accept, start, last;

  always_comb begin
    accept = (op_code_i != OP_NOP) && !busy_q;
    start  = accept && (op_code_i != OP_CLRM);
    clr_o  = accept && (op_code_i == OP_CLRM);
    last   = busy_q && (idx_q == LAST_IDX);
    busy_d = busy_q;
    idx_d  = idx_q;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      idx_d = idx_q + IW'(1);
      if (last) busy_d = 1'b0;
    end
    done_d = last | clr_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      op_q   <= OP_NOP;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
      if (start) op_q <= vmx_op_e'(op_code_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (start) begin
      va_q <= op_va_i;
      vb_q <= op_vb_i;
      sc_q <= scalar_i;
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign idx_o    = idx_q;
  assign op_o     = op_q;
  assign va_o     = va_q;
  assign vb_o     = vb_q;
  assign scalar_o = sc_q;

  // R6
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (busy_q && idx_q == '0));
  // R6
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q != LAST_IDX) |=> busy_q);
  // R7
  last_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q == LAST_IDX) |=> (done_q && !busy_q));
  // R8
  op_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> (op_q == $past(op_q)));
endmodule

// File: rtl/vmx_unit.sv
`timescale 1ns/1ps
module vmx_unit
  import vmx_pkg::*;
#(
  parameter int W     = 16,
  parameter int VLEN  = 64,
  parameter int NREGS = 4,
  localparam int IW   = $clog2(VLEN),
  localparam int RW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      op_code,
  input  logic [RW-1:0]   op_va,
  input  logic [RW-1:0]   op_vb,
  input  logic [W-1:0]    scalar_in,
  output logic            busy,
  output logic            done,
  input  logic            host_we,
  input  logic [RW-1:0]   host_wreg,
  input  logic [IW-1:0]   host_widx,
  input  logic [W-1:0]    host_wdata,
  input  logic [RW-1:0]   host_rreg,
  input  logic [IW-1:0]   host_ridx,
  output logic [W-1:0]    host_rdata,
  output logic [VLEN-1:0] mask_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          clr, busy_w;
  logic [IW-1:0] idx;
  vmx_op_e       cur_op;
  logic [RW-1:0] cur_va, cur_vb;
  logic [W-1:0]  cur_sc, elem_a, elem_b, diff;
  logic          cmp_en, sub_we, host_we_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  vmx_seq #(.W(W), .VLEN(VLEN), .NREGS(NREGS)) seq_i (
    .clk_i(clk), .rst_ni(rst_int_n),
    .op_code_i(op_code), .op_va_i(op_va), .op_vb_i(op_vb), .scalar_i(scalar_in),
    .busy_o(busy_w), .done_o(done), .clr_o(clr), .idx_o(idx),
    .op_o(cur_op), .va_o(cur_va), .vb_o(cur_vb), .scalar_o(cur_sc)
  );

  always_comb begin
    cmp_en     = busy_w && (cur_op == OP_SNE);
    sub_we     = busy_w && (cur_op == OP_SUBM) && mask_o[idx];
    diff       = elem_a - elem_b;
    host_we_ok = host_we && !busy_w;
  end

  vmx_mask #(.VLEN(VLEN)) mask_i (
    .clk_i(clk), .rst_ni(rst_int_n), .clr_i(clr),
    .set_en_i(cmp_en), .set_idx_i(idx), .set_val_i(elem_a != cur_sc),
    .mask_o(mask_o)
  );

  vmx_regfile #(.W(W), .VLEN(VLEN), .NREGS(NREGS)) rf_i (
    .clk_i(clk), .rst_ni(rst_int_n),
    .eng_we_i(sub_we), .eng_wreg_i(cur_va), .eng_widx_i(idx), .eng_wdata_i(diff),
    .host_we_i(host_we_ok), .host_wreg_i(host_wreg), .host_widx_i(host_widx),
    .host_wdata_i(host_wdata),
    .pa_reg_i(cur_va), .pa_idx_i(idx), .pa_data_o(elem_a),
    .pb_reg_i(cur_vb), .pb_idx_i(idx), .pb_data_o(elem_b),
    .pc_reg_i(host_rreg), .pc_idx_i(host_ridx), .pc_data_o(host_rdata)
  );

  assign busy = busy_w;

  // R9
  host_drop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (host_we && busy) |-> !host_we_ok);
  // R11
  nop_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy && op_code == 2'b00) |=> !busy);
endmodule

// File: tb/vmx_unit_tb_top.sv
`timescale 1ns/1ps
module vmx_unit_tb_top;
  localparam int W = 16, VLEN = 64, NREGS = 4;
  localparam int IW = $clog2(VLEN), RW = $clog2(NREGS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] op_code = 2'b00;
  logic [RW-1:0] op_va = '0, op_vb = '0;
  logic [W-1:0] scalar_in = '0;
  logic busy, done;
  logic host_we = 1'b0;
  logic [RW-1:0] host_wreg = '0, host_rreg = '0;
  logic [IW-1:0] host_widx = '0, host_ridx = '0;
  logic [W-1:0] host_wdata = '0, host_rdata;
  logic [VLEN-1:0] mask_o;

  vmx_unit #(.W(W), .VLEN(VLEN), .NREGS(NREGS)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_va(op_va), .op_vb(op_vb),
    .scalar_in(scalar_in), .busy(busy), .done(done), .host_we(host_we),
    .host_wreg(host_wreg), .host_widx(host_widx), .host_wdata(host_wdata),
    .host_rreg(host_rreg), .host_ridx(host_ridx), .host_rdata(host_rdata),
    .mask_o(mask_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit rd_cmp = 1'b0, live_cmp = 1'b0, ended = 1'b0;

  // reference model state
  logic [W-1:0] m_rf [NREGS][VLEN];
  logic [VLEN-1:0] m_mask = '1;
  bit m_busy = 0, m_done = 0;
  int m_idx = 0, m_op = 0, m_va = 0, m_vb = 0;
  logic [W-1:0] m_sc = '0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = '1; m_busy = 0; m_done = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      m_done = 0;
      if (m_busy) begin
        if (m_op == 1) m_mask[m_idx] = (m_rf[m_va][m_idx] != m_sc);
        else if (m_mask[m_idx]) m_rf[m_va][m_idx] = m_rf[m_va][m_idx] - m_rf[m_vb][m_idx];
        if (m_idx == VLEN-1) begin m_busy = 0; m_done = 1; end
        else m_idx++;
      end else if (op_code == 2'b01 || op_code == 2'b10) begin
        m_busy = 1; m_idx = 0; m_op = int'(op_code);
        m_va = int'(op_va); m_vb = int'(op_vb); m_sc = scalar_in;
      end else if (op_code == 2'b11) begin
        m_mask = '1; m_done = 1;
      end
      if (host_we && !was_busy) m_rf[host_wreg][host_widx] = host_wdata;
    end
  end

  always @(negedge clk) begin
    if (live_cmp) begin
      check("R6 busy", 64'(busy), 64'(m_busy));
      check("R7 done", 64'(done), 64'(m_done));
      check("R2/R3 mask", 64'(mask_o), 64'(m_mask));
      if (rd_cmp) check("R4 rdata", 64'(host_rdata), 64'(m_rf[host_rreg][host_ridx]));
    end
  end

  task automatic step;
    @(posedge clk); #2;
  endtask

  task automatic issue(logic [1:0] oc, int va, int vb, logic [W-1:0] sc);
    op_code = oc; op_va = RW'(va); op_vb = RW'(vb); scalar_in = sc;
    step();
    op_code = 2'b00;
  endtask

  task automatic wait_done;
    for (int k = 0; k < 200; k++) begin
      if (m_done) break;
      step();
    end
  endtask

  task automatic read_chk(string tag, int r, int i);
    host_rreg = RW'(r); host_ridx = IW'(i);
    @(negedge clk);
    check(tag, 64'(host_rdata), 64'(m_rf[r][i]));
    step();
  endtask

  task automatic report;
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) step();
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    check("R1 mask", 64'(mask_o), '1);
    live_cmp = 1'b1;
    step();
    // fill register file
    for (int r = 0; r < NREGS; r++)
      for (int i = 0; i < VLEN; i++) begin
        host_we = 1'b1; host_wreg = RW'(r); host_widx = IW'(i);
        case (r)
          0: host_wdata = (i % 4 == 0) ? '0 : W'(i * 3 + 1);
          1: host_wdata = W'(i + 1);
          2: host_wdata = (i % 3 == 0) ? W'(5) : W'(i);
          default: host_wdata = W'(i * 7);
        endcase
        step();
      end
    host_we = 1'b0;
    rd_cmp = 1'b1;
    // R4 full-mask subtract; R8 and R9 collisions in mid-run
    issue(2'b10, 3, 1, '0);
    repeat (5) step();
    host_we = 1'b1; host_wreg = 2'd2; host_widx = 6'd9; host_wdata = 16'hBEEF;
    op_code = 2'b11;
    step();
    host_we = 1'b0; op_code = 2'b01; scalar_in = '0;
    step();
    op_code = 2'b00;
    wait_done();
    read_chk("R9 dropped host write", 2, 9);
    read_chk("R4 subtract elem 10", 3, 10);
    check("R8 mask untouched", 64'(mask_o), '1);
    // R2 compare then R10 back-to-back subtract in the done cycle
    issue(2'b01, 0, 0, '0);
    wait_done();
    check("R10 done seen before chained issue", 64'(done), 64'd1);
    issue(2'b10, 0, 1, '0);
    wait_done();
    for (int i = 0; i < VLEN; i++) read_chk("R5 masked elem", 0, i);
    // R11 no-op
    repeat (4) step();
    check("R11 idle after nop", 64'(busy), 64'd0);
    // R3 clear
    issue(2'b11, 0, 0, '0);
    @(negedge clk);
    check("R3 mask all ones", 64'(mask_o), '1);
    check("R3 no busy", 64'(busy), 64'd0);
    step();
    // compare against 5 on a register with repeats, then masked subtract
    issue(2'b01, 2, 0, 16'd5);
    wait_done();
    step();
    issue(2'b10, 2, 2, '0);
    wait_done();
    for (int i = 0; i < 12; i++) read_chk("R5 zeroing pattern", 2, i);
    // R9 idle host write lands
    host_we = 1'b1; host_wreg = 2'd1; host_widx = 6'd63; host_wdata = 16'h1234;
    step();
    host_we = 1'b0;
    read_chk("R9 idle host write", 1, 63);
    repeat (3) step();
    report();
  end
endmodule